// File: doc/BRIEF.md
# Digital frequency-locking calibration controller

This block trims a controlled oscillator until the number of oscillator cycles in one period of a slow reference tick equals a programmable target. The reference is a 32768 Hz source divided by eight, so a target of N asks for an oscillator running at N × 4096 Hz. The block runs on the oscillator clock itself. A counter runs on that clock, and its value is captured on every rising edge of the reference. The count seen over the last reference period is compared with the target, and the tuning code is moved one step up or down.

The tuning code has two parts: a fine word and a coarse range select above it. The fine word wraps, and its carry or borrow moves the coarse select, which stops at its ends. When one measured period matches the target exactly, the block raises a done level. It then freezes its counter and capture logic and leaves the tuning code where it stopped. A start pulse clears done and resumes the search from the code currently held.

Top module: `freq_lock_cal`

## Requirements
- R1: A synchronous active-high reset sets the fine word to 0, the coarse select to 0 and done low, and leaves the block idle with no adjustments until a start pulse.
- R2: The reference tick goes through a two-stage synchronizer and a rising-edge detector. While calibrating, each rising reference edge produces exactly one decision (one code step, or lock). The code does not change between edges.
- R3: If the measured count is below the target, the fine word is incremented. If it is above the target, the fine word is decremented.
- R4: A fine increment from its all-ones value wraps the fine word to 0 and raises the coarse select by one. If the coarse select is already at its maximum of 7, it is held at 7.
- R5: A fine decrement from 0 wraps the fine word to all ones and lowers the coarse select by one. If the coarse select is already 0, it is held at 0.
- R6: When the measured count equals the target, done goes high and the counter and capture stop. Fine and coarse keep their final values, and done stays high on later reference edges until the next start.
- R7: A start pulse clears done, the cycle counter and the previous capture in the next cycle. The search continues from the current fine and coarse values, without resetting them. Because of the cleared capture, the first comparison uses the raw capture.
- R8: The measured count is the current capture minus the previous one, modulo 2^16. At lock, the oscillator's true cycles per reference period lie within one count of the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, the block's only clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a calibration |
| target | input | 16 | Wanted oscillator cycles per reference period |
| ref_tick | input | 1 | Slow reference, asynchronous to clk |
| fine_code | output | FINE_W (8) | Fine tuning word |
| coarse_sel | output | RANGE_W (3) | Coarse range select |
| done | output | 1 | High once the target count has been matched |

## Verification
The bench builds the block with FINE_W = 5, keeping RANGE_W = 3 and a 16-bit counter. This gives a 256-step tuning code, so both coarse saturation ends and both carry and borrow crossings occur within a few hundred reference periods. The bench models the oscillator period as falling linearly with {coarse, fine}. It locks upward across a carry and then downward across a borrow. It drives unreachable targets to reach each end of the code range, and it counts code steps against reference edges.

// File: rtl/freq_lock_cal.sv
module freq_lock_cal #(
  parameter int CNT_W   = 16,
  parameter int FINE_W  = 8,
  parameter int RANGE_W = 3,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CNT_W-1:0]   target,
  input  logic               ref_tick,
  output logic [FINE_W-1:0]  fine_code,
  output logic [RANGE_W-1:0] coarse_sel,
  output logic               done
);
  localparam logic [RANGE_W-1:0] CMAX = '1;
  localparam logic [RANGE_W-1:0] CMIN = '0;

  logic [SYNC_N:0]    ref_sh;
  logic               tick_rise;
  logic               running;
  logic [CNT_W-1:0]   cnt, prev, meas;
  logic [FINE_W:0]    fine_up, fine_dn;

  assign tick_rise = ref_sh[SYNC_N-1] & ~ref_sh[SYNC_N];
  assign meas      = cnt - prev;
  assign fine_up   = {1'b0, fine_code} + (FINE_W+1)'(1);
  assign fine_dn   = {1'b0, fine_code} - (FINE_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) ref_sh <= '0;
    else     ref_sh <= {ref_sh[SYNC_N-1:0], ref_tick};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      done       <= 1'b0;
      cnt        <= '0;
      prev       <= '0;
      fine_code  <= '0;
      coarse_sel <= '0;
    end else if (start) begin
      running <= 1'b1;
      done    <= 1'b0;
      cnt     <= '0;
      prev    <= '0;
    end else if (running) begin
      cnt <= cnt + CNT_W'(1);
      if (tick_rise) begin
        prev <= cnt;
        if (meas < target) begin
          fine_code <= fine_up[FINE_W-1:0];
          if (fine_up[FINE_W] && coarse_sel != CMAX)
            coarse_sel <= coarse_sel + RANGE_W'(1);
        end else if (meas > target) begin
          fine_code <= fine_dn[FINE_W-1:0];
          if (fine_dn[FINE_W] && coarse_sel != CMIN)
            coarse_sel <= coarse_sel - RANGE_W'(1);
        end else begin
          done    <= 1'b1;
          running <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/freq_lock_cal_chk.sv
module freq_lock_cal_chk #(
  parameter int CNT_W   = 16,
  parameter int FINE_W  = 8,
  parameter int RANGE_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [CNT_W-1:0]   target,
  input logic [CNT_W-1:0]   meas,
  input logic               tick_rise,
  input logic               running,
  input logic [FINE_W-1:0]  fine_code,
  input logic [RANGE_W-1:0] coarse_sel,
  input logic               done
);
  localparam logic [FINE_W-1:0]  FMAX = '1;
  localparam logic [RANGE_W-1:0] CMAX = '1;

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (fine_code == '0 && coarse_sel == '0 && !done));

  a_r2_step_only_on_edge: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && {coarse_sel, fine_code} != $past({coarse_sel, fine_code}))
      |-> $past(tick_rise && running && !start));

  a_r3_raise_when_slow: assert property (@(posedge clk) disable iff (rst)
    (tick_rise && running && !start && meas < target && fine_code != FMAX)
      |=> fine_code == $past(fine_code) + FINE_W'(1));

  a_r4_carry_into_range: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fine_code) == FMAX && fine_code == '0)
      |-> coarse_sel == (($past(coarse_sel) == CMAX) ? CMAX : $past(coarse_sel) + RANGE_W'(1)));

  a_r5_borrow_from_range: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fine_code) == '0 && fine_code == FMAX)
      |-> coarse_sel == (($past(coarse_sel) == '0) ? '0 : $past(coarse_sel) - RANGE_W'(1)));

  a_r6_frozen_after_lock: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(fine_code) && $stable(coarse_sel)));

  a_r7_start_clears_done: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && running));
endmodule

bind freq_lock_cal freq_lock_cal_chk #(
  .CNT_W(CNT_W), .FINE_W(FINE_W), .RANGE_W(RANGE_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .target(target), .meas(meas),
  .tick_rise(tick_rise), .running(running), .fine_code(fine_code),
  .coarse_sel(coarse_sel), .done(done)
);

// File: tb/freq_lock_cal_test.sv
`timescale 1ps/1ps
module freq_lock_cal_test;
  localparam int FW = 5;
  localparam int RW = 3;
  localparam int CW = 16;
  localparam int CODE_W = FW + RW;
  localparam int FMAX = (1 << FW) - 1;
  localparam int CMAX = (1 << RW) - 1;
  localparam int CLK_PERIOD_PS = 20000;
  localparam int STEP_PS = 64;
  localparam int REF_PS = 1_000_000;
  localparam longint WD_PS = 700_000_000;

  logic clk = 0, rst = 1, start = 0, ref_tick = 0;
  logic [CW-1:0] target = '0;
  logic [FW-1:0] fine;
  logic [RW-1:0] coarse;
  logic done;

  freq_lock_cal #(.CNT_W(CW), .FINE_W(FW), .RANGE_W(RW)) uut (
    .clk(clk), .rst(rst), .start(start), .target(target), .ref_tick(ref_tick),
    .fine_code(fine), .coarse_sel(coarse), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  int rc = 0, ticks = 0, changes = 0;
  bit mon = 0;
  logic [CODE_W-1:0] last_code = '0;

  function automatic int code_now();
    if ($isunknown({coarse, fine})) return 0;
    return int'({coarse, fine});
  endfunction

  function automatic int osc_period(input int c);
    return CLK_PERIOD_PS - STEP_PS * c;
  endfunction

  always begin
    #(osc_period(code_now()) / 2) clk = ~clk;
  end

  always #(REF_PS / 2) ref_tick = ~ref_tick;

  always @(posedge ref_tick) begin
    rc++;
    if (mon) ticks++;
  end

  always @(negedge clk) begin
    if (mon && {coarse, fine} !== last_code) changes++;
    last_code = {coarse, fine};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic kick(input int tgt);
    @(posedge ref_tick);
    repeat (4) @(negedge clk);
    target = CW'(tgt);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_code(input int want, input int max_ticks, output bit hit);
    int r0 = rc;
    hit = 0;
    while (rc - r0 < max_ticks) begin
      @(negedge clk);
      if (code_now() == want) begin hit = 1; break; end
    end
  endtask

  task automatic wait_change(input int max_ticks, output bit hit);
    int r0 = rc;
    int c0 = code_now();
    hit = 0;
    while (rc - r0 < max_ticks) begin
      @(negedge clk);
      if (code_now() != c0) begin hit = 1; break; end
    end
  endtask

  task automatic wait_done(input int max_ticks);
    int r0 = rc;
    while (!done && rc - r0 < max_ticks) @(negedge clk);
  endtask

  task automatic check_window(input string req, input int tgt);
    longint p = longint'(osc_period(code_now()));
    longint err = longint'(REF_PS) - longint'(tgt) * p;
    if (err < 0) err = -err;
    chk(err < p, req, "true count within one of target (error ps)", err, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(fine == 0, "R1", "fine after reset", fine, 0);
    chk(coarse == 0, "R1", "coarse after reset", coarse, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    begin
      int c0 = code_now();
      repeat (3) @(posedge ref_tick);
      repeat (5) @(negedge clk);
      chk(code_now() == c0, "R1", "idle code unchanged without start", code_now(), c0);
    end
  endtask

  task automatic t_low_saturation();
    bit hit;
    do_reset();
    kick(10);
    wait_change(3, hit);
    chk(hit, "R5", "a step happened", hit, 1);
    chk(fine == FMAX, "R5", "fine wraps down", fine, FMAX);
    chk(coarse == 0, "R5", "coarse held at 0", coarse, 0);
    wait_change(3, hit);
    chk(fine == FMAX - 1, "R3", "fine decrements when too fast", fine, FMAX - 1);
    chk(done == 0, "R3", "no lock on mismatch", done, 0);
  endtask

  task automatic t_high_saturation();
    bit hit;
    do_reset();
    kick(1000);
    wait_change(3, hit);
    chk(code_now() == 1, "R3", "fine increments when too slow", code_now(), 1);
    wait_code(FMAX, 80, hit);
    wait_change(3, hit);
    chk(fine == 0 && coarse == 1, "R4", "carry raises coarse (code)", code_now(), FMAX + 1);
    wait_code((CMAX << FW) | FMAX, 400, hit);
    chk(hit, "R4", "top code reached", hit, 1);
    wait_change(3, hit);
    chk(fine == 0, "R4", "fine wraps at top", fine, 0);
    chk(coarse == CMAX, "R4", "coarse held at max", coarse, CMAX);
    do_reset();
    chk(code_now() == 0 && done == 0, "R1", "reset aborts run", code_now(), 0);
  endtask

  task automatic t_lock_up();
    do_reset();
    kick(60);
    ticks = 0; changes = 0; last_code = {coarse, fine}; mon = 1;
    wait_done(200);
    repeat (5) @(negedge clk);
    mon = 0;
    chk(done == 1, "R6", "done after upward search", done, 1);
    chk(coarse == 1, "R4", "search crossed a carry", coarse, 1);
    check_window("R8", 60);
    chk(changes == ticks - 1, "R2", "one step per reference edge", changes, ticks - 1);
  endtask

  task automatic t_hold();
    int c0 = code_now();
    repeat (3) @(posedge ref_tick);
    repeat (5) @(negedge clk);
    chk(code_now() == c0, "R6", "code frozen after lock", code_now(), c0);
    chk(done == 1, "R6", "done stays high", done, 1);
  endtask

  task automatic t_lock_down();
    int c0 = code_now();
    kick(52);
    chk(done == 0, "R7", "start clears done", done, 0);
    chk(code_now() == c0, "R7", "start keeps code", code_now(), c0);
    wait_done(200);
    chk(done == 1, "R6", "done after downward search", done, 1);
    chk(coarse == 0, "R5", "search crossed a borrow", coarse, 0);
    check_window("R8", 52);
  endtask

  initial begin
    #(WD_PS);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_low_saturation();
    t_high_saturation();
    t_lock_up();
    t_hold();
    t_lock_down();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule